// File: doc/BRIEF.md
# Scoreboard Computation Unit Controller

This block is the control logic for one function unit in a dependency-matrix scoreboard. The unit takes an issued operation and asks for each source operand it needs. Requests are made by operand slot index, never by architectural register. It latches each operand when the matching read grant arrives. It then offers the full operand set to an execution pipeline over a valid/ready handshake. When the operation produces a result, the unit captures the returned value, raises a write request and holds it until the write grant arrives. Only after that does it report completion.

The unit has no sequencer of its own. Each step follows from a blockage being acknowledged: a read grant, pipeline acceptance, a returning result or a write grant. An operation flagged as having no result, such as a store, skips the result and write phases. It completes as soon as the pipeline has taken its inputs. The latches hold bare data. The register identity of each operand lives only in the external dependency matrix row paired with this unit.

Top module: `cu_ctrl`

## Requirements
- R1: During and directly after reset, busy_o, done_o, pipe_valid_o, wr_req_o and every bit of rd_req_o are low.
- R2: An issue_i pulse while idle makes busy_o high from the next cycle. It also captures need_i and has_result_i. Bit k of need_i selects operand slot k, where slot k's data occupies bits [k*DATA_W +: DATA_W] of rd_data_i and pipe_op_o.
- R3: From the cycle after issue, rd_req_o[k] is high for each needed slot k. It falls in the cycle after go_rd_i[k] is seen with it. It does not affect the request of any other slot.
- R4: Slot k latches rd_data_i only in a cycle where both rd_req_o[k] and go_rd_i[k] are high. Data present at other times is ignored. The latched value is what pipe_op_o carries to the pipeline.
- R5: pipe_valid_o is never high while any needed operand is still ungranted. Once raised, it stays high until pipe_ready_i is seen.
- R6: For a result-producing operation, res_data_i is captured on the first res_valid_i after pipeline acceptance. From the next cycle, wr_req_o stays high with wr_data_o equal to that value, until go_wr_i is seen.
- R7: For a result-producing operation, done_o rises exactly one cycle after go_wr_i is accepted, and never earlier.
- R8: For an operation issued with has_result_i low, wr_req_o never rises. done_o rises exactly one cycle after the pipeline handshake.
- R9: done_o is a single-cycle pulse. busy_o is low in the cycle after it.
- R10: issue_i while busy is ignored. The operand requests, the result/no-result path and the completion cycle of the operation in flight are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue strobe for a new operation |
| need_i | input | NUM_OPS | Per-slot operand-needed mask, sampled at issue |
| has_result_i | input | 1 | Operation writes a result, sampled at issue |
| rd_req_o | output | NUM_OPS | Per-slot operand read request |
| go_rd_i | input | NUM_OPS | Per-slot read grant |
| rd_data_i | input | NUM_OPS*DATA_W | Operand data, valid with the matching grant |
| pipe_valid_o | output | 1 | Operand set offered to the pipeline |
| pipe_ready_i | input | 1 | Pipeline accepts the operand set |
| pipe_op_o | output | NUM_OPS*DATA_W | Latched operands |
| res_valid_i | input | 1 | Pipeline result valid |
| res_data_i | input | DATA_W | Pipeline result data |
| wr_req_o | output | 1 | Result write request |
| go_wr_i | input | 1 | Write grant |
| wr_data_o | output | DATA_W | Latched result |
| busy_o | output | 1 | Operation in flight, issue through done |
| done_o | output | 1 | Completion pulse |

## Verification
The bench sweeps every needed-operand mask, both result and no-result operations, and staggered grant, ready, result and write delays.

- A unit that signals done at pipeline acceptance shows done_o ahead of the write grant on result operations.
- A unit that always takes the write path raises wr_req_o on a store.
- A grant applied to the wrong slot, or operand data latched without a grant, shows up as a request that stays high or a corrupted pipe_op_o.

Stray issue pulses during an operation, with the opposite result flag, expose a unit that re-arms its requests or switches path in mid-flight.

// File: rtl/cuc_pkg.sv
package cuc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OFFER,
        ST_AWAIT,
        ST_WRITE,
        ST_DONE
    } cu_state_e;

    typedef struct packed {
        cu_state_e state;
        logic      has_res;
    } cu_ctl_t;

endpackage

// File: rtl/cuc_operand_slot.sv
module cuc_operand_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              need_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              pending;
        logic [DATA_W-1:0] value;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load_i) begin
            slot_d.pending = need_i;
        end else if (slot_q.pending && go_i) begin
            slot_d.pending = 1'b0;
            slot_d.value   = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign req_o  = slot_q.pending;
    assign data_o = slot_q.value;

    // R3: a granted request is withdrawn on the following cycle
    a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && go_i && !load_i) |=> !req_o);

    // R4: the latch follows the bus only under a grant
    a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_o && go_i)) |=> $stable(data_o));

endmodule

// File: rtl/cuc_result_slot.sv
module cuc_result_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (capture_i) begin
            value_d = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

    assign data_o = value_q;

    // R6: captured value appears on the output the next cycle
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (data_o == $past(data_i)));

endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl #(
    parameter int NUM_OPS = 2,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue_i,
    input  logic [NUM_OPS-1:0]        need_i,
    input  logic                      has_result_i,
    output logic [NUM_OPS-1:0]        rd_req_o,
    input  logic [NUM_OPS-1:0]        go_rd_i,
    input  logic [NUM_OPS*DATA_W-1:0] rd_data_i,
    output logic                      pipe_valid_o,
    input  logic                      pipe_ready_i,
    output logic [NUM_OPS*DATA_W-1:0] pipe_op_o,
    input  logic                      res_valid_i,
    input  logic [DATA_W-1:0]         res_data_i,
    output logic                      wr_req_o,
    input  logic                      go_wr_i,
    output logic [DATA_W-1:0]         wr_data_o,
    output logic                      busy_o,
    output logic                      done_o
);
    import cuc_pkg::*;

    localparam int BUS_W = NUM_OPS * DATA_W;

    cu_ctl_t ctl_d, ctl_q;
    logic    load_w;
    logic    res_cap_w;
    logic    all_clear_w;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_slot
        cuc_operand_slot #(.DATA_W(DATA_W)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .need_i (need_i[k]),
            .go_i   (go_rd_i[k]),
            .data_i (rd_data_i[k*DATA_W +: DATA_W]),
            .req_o  (rd_req_o[k]),
            .data_o (pipe_op_o[k*DATA_W +: DATA_W])
        );
    end

    cuc_result_slot #(.DATA_W(DATA_W)) res_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (res_cap_w),
        .data_i    (res_data_i),
        .data_o    (wr_data_o)
    );

    assign all_clear_w = ~|rd_req_o;

    always_comb begin
        ctl_d        = ctl_q;
        load_w       = 1'b0;
        res_cap_w    = 1'b0;
        pipe_valid_o = 1'b0;
        wr_req_o     = 1'b0;
        done_o       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (issue_i) begin
                    load_w        = 1'b1;
                    ctl_d.has_res = has_result_i;
                    ctl_d.state   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (all_clear_w) begin
                    ctl_d.state = ST_OFFER;
                end
            end
            ST_OFFER: begin
                pipe_valid_o = 1'b1;
                if (pipe_ready_i) begin
                    ctl_d.state = ctl_q.has_res ? ST_AWAIT : ST_DONE;
                end
            end
            ST_AWAIT: begin
                if (res_valid_i) begin
                    res_cap_w   = 1'b1;
                    ctl_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                wr_req_o = 1'b1;
                if (go_wr_i) begin
                    ctl_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                done_o      = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, has_res: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.state != ST_IDLE);

    // R2: issue while idle starts an operation
    a_r2_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && issue_i) |=> busy_o);

    // R5: no offer to the pipeline with an operand outstanding
    a_r5_offer_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_valid_o |-> (rd_req_o == '0));

    // R5: an offer is held until accepted
    a_r5_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_valid_o && !pipe_ready_i) |=> pipe_valid_o);

    // R6: write request is held until granted
    a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !go_wr_i) |=> wr_req_o);

    // R7: result operation completes only after a write grant
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ctl_q.has_res) |-> $past(wr_req_o && go_wr_i));

    // R8: no-result operation completes right after pipeline acceptance
    a_r8_store_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ctl_q.has_res) |-> $past(pipe_valid_o && pipe_ready_i));

    // R8: no write request for a no-result operation
    a_r8_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ctl_q.has_res) |-> !wr_req_o);

    // R9: done is a pulse and ends the busy period
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10: a busy unit stays busy through a stray issue
    a_r10_issue_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && issue_i) |=> busy_o);

endmodule

// File: tb/cu_ctrl_tb_top.sv
module cu_ctrl_tb_top;

    localparam int NOPS = 2;
    localparam int DW   = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 issue_i = 1'b0;
    logic [NOPS-1:0]      need_i = '0;
    logic                 has_result_i = 1'b0;
    logic [NOPS-1:0]      rd_req_o;
    logic [NOPS-1:0]      go_rd_i = '0;
    logic [NOPS*DW-1:0]   rd_data_i = '0;
    logic                 pipe_valid_o;
    logic                 pipe_ready_i = 1'b0;
    logic [NOPS*DW-1:0]   pipe_op_o;
    logic                 res_valid_i = 1'b0;
    logic [DW-1:0]        res_data_i = '0;
    logic                 wr_req_o;
    logic                 go_wr_i = 1'b0;
    logic [DW-1:0]        wr_data_o;
    logic                 busy_o;
    logic                 done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cu_ctrl #(.NUM_OPS(NOPS), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .need_i(need_i),
        .has_result_i(has_result_i), .rd_req_o(rd_req_o), .go_rd_i(go_rd_i),
        .rd_data_i(rd_data_i), .pipe_valid_o(pipe_valid_o),
        .pipe_ready_i(pipe_ready_i), .pipe_op_o(pipe_op_o),
        .res_valid_i(res_valid_i), .res_data_i(res_data_i),
        .wr_req_o(wr_req_o), .go_wr_i(go_wr_i), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] need, input logic hr,
                          input int d, input int seq, input bit poke);
        logic [1:0]  granted = '0;
        bit          accepted = 0;
        bit          res_sent = 0;
        bit          wr_granted = 0;
        bit          done_exp = 0;
        bit          fin = 0;
        int          wait_k[2] = '{0, 0};
        int          gd[2];
        int          cnt_rdy = 0;
        int          cnt_res = 0;
        int          cnt_wr = 0;
        logic [15:0] opv[2];
        logic [15:0] res_v;
        gd[0]  = d;
        gd[1]  = (d + 1) % 3;
        opv[0] = 16'h1000 + 16'(seq);
        opv[1] = 16'h2000 + 16'(seq);
        res_v  = 16'hC000 + 16'(seq);

        @(negedge clk);
        issue_i = 1'b1; need_i = need; has_result_i = hr;
        @(negedge clk);
        issue_i = 1'b0; need_i = ~need; has_result_i = ~hr;
        chk(busy_o == 1'b1, "R2 busy after issue", 32'(busy_o), 32'd1);

        for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
            if (cyc > 0) @(negedge clk);
            // sample
            chk(rd_req_o == (need & ~granted), "R3 R10 read requests",
                32'(rd_req_o), 32'(need & ~granted));
            if (pipe_valid_o) begin
                chk(granted == need, "R5 offer before reads",
                    32'(granted), 32'(need));
                for (int k = 0; k < NOPS; k++) begin
                    if (need[k])
                        chk(pipe_op_o[k*DW +: DW] == opv[k], "R4 operand latch",
                            32'(pipe_op_o[k*DW +: DW]), 32'(opv[k]));
                end
            end
            chk(wr_req_o == (hr && res_sent && !wr_granted), "R6 R8 write request",
                32'(wr_req_o), 32'(hr && res_sent && !wr_granted));
            if (wr_req_o)
                chk(wr_data_o == res_v, "R6 write data", 32'(wr_data_o), 32'(res_v));
            chk(done_o == done_exp, hr ? "R7 done timing" : "R8 done timing",
                32'(done_o), 32'(done_exp));
            chk(busy_o == 1'b1, "R9 busy until done", 32'(busy_o), 32'd1);
            if (done_o) fin = 1;

            // drive
            issue_i      = poke && (cyc == 1);  // R10 stray issue
            has_result_i = ~hr;
            need_i       = ~need;
            done_exp     = 0;
            go_rd_i      = '0;
            for (int k = 0; k < NOPS; k++) begin
                rd_data_i[k*DW +: DW] = 16'hBAD0 | 16'(k);
                if (rd_req_o[k]) begin
                    if (wait_k[k] >= gd[k]) begin
                        go_rd_i[k] = 1'b1;
                        rd_data_i[k*DW +: DW] = opv[k];
                        granted[k] = 1'b1;
                    end
                    wait_k[k]++;
                end
            end
            res_valid_i = 1'b0;
            res_data_i  = 16'h5A5A;
            if (accepted && hr && !res_sent) begin
                if (cnt_res >= d) begin
                    res_valid_i = 1'b1;
                    res_data_i  = res_v;
                    res_sent    = 1;
                end
                cnt_res++;
            end
            pipe_ready_i = 1'b0;
            if (pipe_valid_o) begin
                if (cnt_rdy >= d) begin
                    pipe_ready_i = 1'b1;
                    accepted     = 1;
                    if (!hr) done_exp = 1;
                end
                cnt_rdy++;
            end
            go_wr_i = 1'b0;
            if (wr_req_o) begin
                if (cnt_wr >= 2 - d) begin
                    go_wr_i    = 1'b1;
                    wr_granted = 1;
                    done_exp   = 1;
                end
                cnt_wr++;
            end
        end
        issue_i = 1'b0; go_rd_i = '0; pipe_ready_i = 1'b0;
        res_valid_i = 1'b0; go_wr_i = 1'b0;
        chk(fin, hr ? "R7 completion" : "R8 completion", 32'(fin), 32'd1);
        @(negedge clk);
        chk(!busy_o && !done_o, "R9 idle after done",
            {30'd0, busy_o, done_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seq = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !pipe_valid_o && !wr_req_o && rd_req_o == '0,
            "R1 reset outputs",
            {27'd0, busy_o, done_o, pipe_valid_o, wr_req_o, |rd_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && rd_req_o == '0, "R1 after reset",
            {30'd0, busy_o, |rd_req_o}, 32'd0);
        for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 2; h++) begin
                for (int d = 0; d < 3; d++) begin
                    seq++;
                    run_op(2'(m), 1'(h), d, seq, (seq % 2) == 1);
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule